// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is the target end of a two-wire serial memory holding 4096 bytes. A fast system clock samples SCL and SDA, which arrive already synchronized. From these samples the block finds START and STOP conditions, shifts in bytes MSB first and answers on the ninth clock. SDA is open drain: the block only ever pulls the line low, through an output enable, to send an ACK or a zero data bit.

Every transaction begins with a command byte. Its upper nibble is a fixed device prefix, bits 3..1 are a chip-select code and bit 0 selects the direction. On a write command the master sends two address bytes and then data bytes, which are stored in the array. A read command returns bytes from an internal address counter. That counter survives across transactions, so the master has three ways to read:
- a current-address read, which sends only a read command;
- a random read, which sends a write command and an address, then a repeated START and a read command;
- a sequential read, which goes on for as long as the master acknowledges.

An external busy input stands for an internal programming cycle. While it is high, no command byte is acknowledged, so the master can poll for completion.

Top module: `serial_mem_target`

## Requirements
- R1: After reset the SDA enable is low and the address counter is 0, so a current-address read returns the byte at address 0.
- R2: A command byte is acknowledged only when bits 7..4 equal 1010 and bits 3..1 equal the chip-select inputs (bit 0: 0 = write, 1 = read). On a mismatch there is no ACK, and all further bytes go unacknowledged until the next START.
- R3: After a write command, the high address byte must carry 0000 in bits 7..4 and address bits 11..8 in bits 3..0, and the low address byte carries bits 7..0. Both are acknowledged and loaded into the counter. A high byte with a nonzero upper nibble is not acknowledged.
- R4: A read sends the byte at the counter MSB first and then advances the counter by one. When the master acknowledges, the next byte follows.
- R5: A read command with no address phase reads from the counter as left by the previous transaction.
- R6: A sequential read past address 4095 continues at address 0.
- R7: A repeated START after the address bytes cancels the write, and the following read command reads from the loaded address.
- R8: While the busy input is high, no command byte is acknowledged, read or write.
- R9: Each acknowledged data byte after the address is stored at the counter. The counter then advances within its 32-byte page only (bits 4..0), so a write past the end of the page wraps to the start of the same page.
- R10: The SDA enable rises only on the clock after a falling SCL edge is seen. During bits that the master drives, the enable stays low.
- R11: A START or STOP in the middle of a byte abandons the transfer. After a START, the next byte is decoded as a fresh command.
- R12: When the master does not acknowledge a read byte, the block stops driving SDA until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized serial clock |
| sda_i | input | 1 | Synchronized serial data line level |
| chip_sel | input | 3 | Hard-wired chip-select code |
| prog_busy | input | 1 | High while a programming cycle is in progress |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
SCL and SDA are compared with their one-cycle-old copies, so an edge or condition is acted on at the first clock edge after the line changes. The ACK or the next data bit therefore appears on the SDA enable one clock after the falling SCL edge is seen. The bench holds every SCL half-period for four system clocks and samples the wired-AND line two clocks into the high phase. By that point any response has been settled for at least four clocks. Every ACK, read byte and released bit is judged at that sample point, and a separate monitor flags any rise of the enable while SCL is high.

// File: rtl/serial_mem_target.sv
`timescale 1ns/1ps
module serial_mem_target #(
  parameter int          ADDR_W = 12,
  parameter int          PAGE_W = 5,
  parameter logic [3:0]  DEV_ID = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] chip_sel,
  input  logic       prog_busy,
  output logic       sda_oe
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int HI_BITS = ADDR_W - 8;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_AHI, S_ALO, S_WDAT, S_RDAT} st_t;

  st_t               state;
  logic              scl_q, sda_q, rw;
  logic [3:0]        cnt;
  logic [7:0]        sh, tx, rd_q;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        mem [DEPTH];

  wire scl_rise = scl_i & ~scl_q;
  wire scl_fall = ~scl_i & scl_q;
  wire start_c  = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  wire cmd_hit  = (sh[7:4] == DEV_ID) && (sh[3:1] == chip_sel) && !prog_busy;
  wire hi_ok    = (sh[7:HI_BITS] == '0);
  wire mem_we   = scl_fall && (cnt == 4'd8) && (state == S_WDAT);
  wire [PAGE_W-1:0] off_inc = addr[PAGE_W-1:0] + 1'b1;

  always_ff @(posedge clk) begin
    if (mem_we) mem[addr] <= sh;
    rd_q <= mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      state  <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      addr   <= '0;
      rw     <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_c) begin
        state  <= S_CMD;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        state  <= S_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (state != S_IDLE) begin
        if (scl_rise) begin
          if (cnt < 4'd8) sh <= {sh[6:0], sda_i};
          cnt <= cnt + 4'd1;
          if (cnt == 4'd8 && state == S_RDAT && sda_i) state <= S_IDLE;
        end else if (scl_fall) begin
          if (cnt == 4'd8) begin
            case (state)
              S_CMD:  if (cmd_hit) begin sda_oe <= 1'b1; rw <= sh[0]; end
                      else state <= S_IDLE;
              S_AHI:  if (hi_ok) begin
                        sda_oe <= 1'b1;
                        addr[ADDR_W-1:8] <= sh[HI_BITS-1:0];
                      end else state <= S_IDLE;
              S_ALO:  begin sda_oe <= 1'b1; addr[7:0] <= sh; end
              S_WDAT: begin sda_oe <= 1'b1; addr[PAGE_W-1:0] <= off_inc; end
              default: sda_oe <= 1'b0;
            endcase
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            case (state)
              S_CMD: if (rw) begin
                       state  <= S_RDAT;
                       tx     <= rd_q;
                       sda_oe <= ~rd_q[7];
                       addr   <= addr + 1'b1;
                     end else begin
                       state  <= S_AHI;
                       sda_oe <= 1'b0;
                     end
              S_AHI:  begin state <= S_ALO;  sda_oe <= 1'b0; end
              S_ALO:  begin state <= S_WDAT; sda_oe <= 1'b0; end
              S_WDAT: sda_oe <= 1'b0;
              S_RDAT: begin
                        tx     <= rd_q;
                        sda_oe <= ~rd_q[7];
                        addr   <= addr + 1'b1;
                      end
              default: ;
            endcase
          end else if (state == S_RDAT && cnt != 4'd0) begin
            sda_oe <= ~tx[6];
            tx     <= {tx[6:0], 1'b0};
          end
        end
      end
    end
  end

  a_r10_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  a_r8_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CMD && $rose(sda_oe)) |-> !$past(prog_busy));

  a_r2_ack_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CMD && $rose(sda_oe)) |->
      ($past(sh[7:4]) == DEV_ID && $past(sh[3:1]) == $past(chip_sel)));

  a_r12_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe);

  a_r6_read_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RDAT && $past(state) == S_RDAT && addr != $past(addr)) |->
      addr == $past(addr) + 1'b1);

  a_r11_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_c) |-> (state == S_CMD && !sda_oe));
endmodule

// File: tb/serial_mem_target_tb.sv
`timescale 1ns/1ps
module serial_mem_target_tb;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
  logic [2:0] cs_pins = 3'b101;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;
  int   n_chk = 0, n_bad = 0, r10_tsk = 0, r10_mon = 0;
  logic [7:0] model [4096];
  logic prev_oe = 1'b0;

  always #4 clk = ~clk;

  serial_mem_target u_dut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
                           .chip_sel(cs_pins), .prog_busy(busy), .sda_oe(sda_oe));

  localparam logic [19:0] VEC [8] = '{
    {12'h000, 8'h5A}, {12'hFFF, 8'hC3}, {12'h123, 8'h01}, {12'h7E0, 8'hFF},
    {12'h03F, 8'h80}, {12'h020, 8'h3C}, {12'h800, 8'h96}, {12'hABC, 8'h00}};

  always @(negedge clk) begin
    if (sda_oe && !prev_oe && scl) r10_mon++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start;
    m_sda = 1'b1; wclk(4); scl = 1'b1; wclk(4); m_sda = 1'b0; wclk(4); scl = 1'b0; wclk(4);
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; wclk(4); scl = 1'b1; wclk(4); m_sda = 1'b1; wclk(4);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wclk(4); scl = 1'b1; wclk(2);
    if (sda_line !== b) r10_tsk++;
    wclk(2); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; wclk(4); scl = 1'b1; wclk(2);
    acked = (sda_line == 1'b0);
    wclk(2); scl = 1'b0; wclk(4);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      wclk(4); scl = 1'b1; wclk(2); d[i] = sda_line; wclk(2); scl = 1'b0;
    end
    m_sda = ~mack; wclk(4); scl = 1'b1; wclk(4); scl = 1'b0; m_sda = 1'b1; wclk(4);
  endtask

  function automatic logic [7:0] cmd(input logic [2:0] cs, input logic rd);
    return {4'b1010, cs, rd};
  endfunction

  task automatic addr_phase(input logic [11:0] a, output logic ok);
    logic k0, k1, k2;
    i2c_start;
    send_byte(cmd(cs_pins, 1'b0), k0);
    send_byte({4'h0, a[11:8]}, k1);
    send_byte(a[7:0], k2);
    ok = k0 & k1 & k2;
  endtask

  task automatic write_bytes(input logic [11:0] a, input logic [7:0] d0, input logic [7:0] d1,
                             input logic [7:0] d2, input int n, output logic ok);
    logic k, ka;
    addr_phase(a, ok);
    send_byte(d0, k); ok &= k;
    if (n > 1) begin send_byte(d1, ka); ok &= ka; end
    if (n > 2) begin send_byte(d2, ka); ok &= ka; end
    i2c_stop;
  endtask

  task automatic rand_read(input logic [11:0] a, output logic ok, output logic [7:0] d);
    logic k;
    addr_phase(a, ok);
    i2c_start;
    send_byte(cmd(cs_pins, 1'b1), k); ok &= k;
    recv_byte(1'b0, d);
    i2c_stop;
  endtask

  task automatic cur_read(output logic ok, output logic [7:0] d);
    i2c_start;
    send_byte(cmd(cs_pins, 1'b1), ok);
    recv_byte(1'b0, d);
    i2c_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ok, k;
    logic [7:0] d, d2;
    wclk(5);
    rst_n = 1'b1;
    wclk(3);
    chk("R1 enable after reset", sda_oe, 1'b0);

    for (int v = 0; v < 8; v++) begin
      write_bytes(VEC[v][19:8], VEC[v][7:0], 8'h00, 8'h00, 1, ok);
      model[VEC[v][19:8]] = VEC[v][7:0];
      chk("R9 write acks", ok, 1'b1);
      rand_read(VEC[v][19:8], ok, d);
      chk("R7 random read acks", ok, 1'b1);
      chk("R7 random read data", d, model[VEC[v][19:8]]);
    end

    rst_n = 1'b0; wclk(3); rst_n = 1'b1; wclk(3);
    cur_read(ok, d);
    chk("R1 counter at zero", d, model[0]);

    write_bytes(12'h123, 8'h11, 8'h22, 8'h33, 3, ok);
    chk("R9 page write acks", ok, 1'b1);
    rand_read(12'h123, ok, d);
    chk("R9 first of page write", d, 8'h11);
    i2c_start; send_byte(cmd(cs_pins, 1'b1), ok);
    recv_byte(1'b1, d); recv_byte(1'b0, d2); i2c_stop;
    chk("R5 current address read", d, 8'h22);
    chk("R4 sequential next byte", d2, 8'h33);

    addr_phase(12'hFFF, ok);
    i2c_start; send_byte(cmd(cs_pins, 1'b1), k);
    recv_byte(1'b1, d); recv_byte(1'b0, d2); i2c_stop;
    chk("R6 last address", d, model[12'hFFF]);
    chk("R6 wrap to zero", d2, model[0]);

    write_bytes(12'h040, 8'h77, 8'h00, 8'h00, 1, ok);
    write_bytes(12'h03F, 8'hAA, 8'hBB, 8'h00, 2, ok);
    chk("R9 rollover write acks", ok, 1'b1);
    rand_read(12'h020, ok, d);
    chk("R9 page wrap target", d, 8'hBB);
    rand_read(12'h040, ok, d);
    chk("R9 next page untouched", d, 8'h77);

    i2c_start; send_byte(cmd(3'b011, 1'b0), k);
    chk("R2 wrong chip select nack", k, 1'b0);
    send_byte(8'h00, k);
    chk("R2 ignored until start", k, 1'b0);
    send_byte(8'h00, k); send_byte(8'h00, k); i2c_stop;
    i2c_start; send_byte({4'b1011, cs_pins, 1'b1}, k); i2c_stop;
    chk("R2 wrong prefix nack", k, 1'b0);
    rand_read(12'h000, ok, d);
    chk("R2 ignored write left data", d, model[0]);

    i2c_start; send_byte(cmd(cs_pins, 1'b0), ok); send_byte(8'h10, k); i2c_stop;
    chk("R3 nonzero high nibble nack", k, 1'b0);

    busy = 1'b1;
    i2c_start; send_byte(cmd(cs_pins, 1'b1), k);
    chk("R8 busy read command", k, 1'b0);
    i2c_start; send_byte(cmd(cs_pins, 1'b0), k); i2c_stop;
    chk("R8 busy write command", k, 1'b0);
    busy = 1'b0;
    i2c_start; send_byte(cmd(cs_pins, 1'b1), k); recv_byte(1'b0, d); i2c_stop;
    chk("R8 ack after busy", k, 1'b1);

    rand_read(12'h123, ok, d);
    i2c_start; send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    i2c_start; send_byte(cmd(cs_pins, 1'b1), k); recv_byte(1'b0, d); i2c_stop;
    chk("R11 start mid byte ack", k, 1'b1);
    chk("R11 start mid byte data", d, 8'h22);
    i2c_start; send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); i2c_stop;
    cur_read(k, d);
    chk("R11 stop mid byte data", d, 8'h33);

    rand_read(12'h7E0, ok, d);
    addr_phase(12'h800, ok);
    i2c_start; send_byte(cmd(cs_pins, 1'b1), k);
    recv_byte(1'b0, d); recv_byte(1'b0, d2); i2c_stop;
    chk("R12 byte before nack", d, model[12'h800]);
    chk("R12 released after nack", d2, 8'hFF);

    chk("R10 master bits undisturbed", r10_tsk, 0);
    chk("R10 no rise while clock high", r10_mon, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule